// File: doc/BRIEF.md
# Banked Serial Register Port

This block is the peripheral side of a four-wire serial link that gives a host access to three banks of 16-bit registers. Every transaction is a fixed 24-bit frame, framed by an active-low chip select. The top byte of the frame is a command or an address, and the lower sixteen bits are a payload. A bank-select register, reached through a fixed address, chooses which bank later reads and writes use.

Reads are pipelined by one frame. A read frame names an address, and the value at that address is shifted back during the next frame. Successive read frames therefore stream data, each returning the previous frame's value. An all-zero frame then drains the last pending value. The serial pins are oversampled by the system clock, so the whole block runs in one clock domain.

Top module: `spi_banked_regs`

## Requirements
- R1: After reset the selection is bank 0 (a read of address 0x02 returns 0x0001), `sdout` is low, and the first frame returns 0x000000.
- R2: A frame is accepted only when `cs_n` rises after exactly 24 rising `sclk` edges, with `sdi` sampled MSB first on those edges. A frame with any other count changes no register, no bank selection and no pending response.
- R3: A frame whose top byte is neither 0x00 nor 0x01 is a write. The top byte is the address, and bits [15:0] are stored at that address in the selected bank.
- R4: A write to address 0x02 sets the selection from whichever bank is current: payload 0x0001 selects bank 0, 0x0002 bank 1 and 0x0004 bank 2. A read of address 0x02 returns the current one-hot selection.
- R5: A write to address 0x02 with any other payload leaves the selection unchanged.
- R6: A read frame has top byte 0x01, the address in bits [15:8] and 0x01 in bits [7:0]. The value is returned in the following frame as bits [23:8], with bits [7:0] zero.
- R7: In back-to-back read frames, each frame returns the data for the previous frame's address.
- R8: Any accepted frame that is not a read makes the next frame return 0x000000. This covers all-zero flush frames, writes, and reads whose bits [7:0] are not 0x01. A flush frame itself returns the pending read data.
- R9: `sdout` shifts the response MSB first. Bit 23 appears after `cs_n` falls, and each later bit appears after a falling `sclk` edge.
- R10: A read takes its data from the bank selected when the read frame is accepted. The three banks hold independent values at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, MSB first |
| sdout | output | 1 | Serial data out, MSB first |

## Verification
The same address is written with different values in all three banks. Reads are then issued in single, back-to-back and flush-terminated sequences, which separates bank steering from pipelining. Reads are also interleaved with writes, malformed reads and frames of 23 and 25 bits, to show which frames clear the pending response and which leave every piece of state untouched. Bank-select payloads that are zero or have two bits set test the one-hot guard. A payload with its top and bottom bits set tests the bit order on `sdout`.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CMD_W      = 8;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 8;
  localparam int NBANK      = 3;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  localparam logic [CMD_W-1:0] CMD_IDLE     = 8'h00;
  localparam logic [CMD_W-1:0] CMD_READ     = 8'h01;
  localparam logic [CMD_W-1:0] ADDR_BANKSEL = 8'h02;
  localparam logic [7:0]       READ_MARK    = 8'h01;

  typedef enum logic [1:0] {
    FK_IDLE,
    FK_READ,
    FK_WRITE,
    FK_BANKSEL
  } frame_kind_e;

  function automatic frame_kind_e classify(input logic [CMD_W-1:0] cmd,
                                           input logic [7:0] low);
    if (cmd == CMD_IDLE)          return FK_IDLE;
    else if (cmd == CMD_READ)     return (low == READ_MARK) ? FK_READ : FK_IDLE;
    else if (cmd == ADDR_BANKSEL) return FK_BANKSEL;
    else                          return FK_WRITE;
  endfunction

  // One bit set, and inside the bank range.
  function automatic logic sel_ok(input logic [DATA_W-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0) && (v < (DATA_W'(1) << NBANK));
  endfunction

  function automatic logic [FRAME_BITS-1:0] response_word(input logic [DATA_W-1:0] d);
    return {d, {(FRAME_BITS-DATA_W){1'b0}}};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_bank_pkg::*;
#(
  parameter int FBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             cs_n_s,
  input  logic             sdi_s,
  input  logic [FBITS-1:0] resp_word,
  output logic             frame_ok,
  output logic             frame_bad,
  output logic [FBITS-1:0] frame_word,
  output logic             sdout
);
  localparam int LCNT = $clog2(FBITS + 2);
  localparam logic [LCNT-1:0] CNT_FULL = LCNT'(FBITS);
  localparam logic [LCNT-1:0] CNT_MAX  = LCNT'(FBITS + 1);

  logic sclk_d, cs_d;
  logic sclk_rise, sclk_fall, frame_start, frame_end;
  logic [LCNT-1:0]  bit_cnt;
  logic [FBITS-1:0] rx_q, tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  // Named events for the assertions and the downstream logic
  assign sclk_rise   = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall   = ~sclk_s & sclk_d & ~cs_n_s;
  assign frame_start = cs_d & ~cs_n_s;
  assign frame_end   = ~cs_d & cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_q    <= '0;
    end else if (frame_start) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      rx_q <= {rx_q[FBITS-2:0], sdi_s};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tx_q <= '0;
    else if (frame_start) tx_q <= resp_word;
    else if (sclk_fall)   tx_q <= {tx_q[FBITS-2:0], 1'b0};
  end

  assign frame_ok   = frame_end && (bit_cnt == CNT_FULL);
  assign frame_bad  = frame_end && (bit_cnt != CNT_FULL);
  assign frame_word = rx_q;
  assign sdout      = tx_q[FBITS-1];

  // R9: sdout only moves at frame start or after a falling serial clock
  p_sdout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !frame_start) |=> $stable(sdout));
  // R9: the first bit shown is the MSB of the pending response
  p_first_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (sdout == $past(resp_word[FBITS-1])));
endmodule

// File: rtl/spi_bank_store.sv
module spi_bank_store
  import spi_bank_pkg::*;
#(
  parameter int BANKS = NBANK,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int FBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_ok,
  input  logic [FBITS-1:0] frame_word,
  output logic [FBITS-1:0] resp_word,
  output logic [BANKS-1:0] bank_sel
);
  localparam int DEPTH = 1 << AW;

  frame_kind_e       kind;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DW-1:0]     payload, rd_mux, rd_value;
  logic              wr_go, sel_go, sel_valid;
  logic [DW-1:0]     rd_bank [BANKS];
  logic [FBITS-1:0]  resp_q;

  assign wr_addr   = frame_word[FBITS-1 -: AW];
  assign rd_addr   = frame_word[DW-1 -: AW];
  assign payload   = frame_word[DW-1:0];
  assign kind      = classify(frame_word[FBITS-1 -: CMD_W], frame_word[7:0]);
  assign wr_go     = frame_ok && (kind == FK_WRITE);
  assign sel_valid = sel_ok(payload);
  assign sel_go    = frame_ok && (kind == FK_BANKSEL) && sel_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_sel <= BANKS'(1);
    else if (sel_go) bank_sel <= payload[BANKS-1:0];
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (wr_go && bank_sel[b]) mem[wr_addr] <= payload;
      end
      assign rd_bank[b] = mem[rd_addr];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_sel[b]) rd_mux = rd_mux | rd_bank[b];
    end
  end

  assign rd_value = (rd_addr == AW'(ADDR_BANKSEL)) ? DW'(bank_sel) : rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else if (frame_ok) resp_q <= (kind == FK_READ) ? response_word(rd_value) : '0;
  end

  assign resp_word = resp_q;

  // R4/R5: selection is always exactly one bank
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_sel) == 1);
  // R5: a rejected selection payload keeps the old bank
  p_bad_sel_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && kind == FK_BANKSEL && !sel_valid) |=> $stable(bank_sel));
  // R6: the low byte of any response is zero
  p_resp_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_q[7:0] == 8'h00);
  // R8: a non-read frame leaves nothing pending
  p_nonread_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && kind != FK_READ) |=> (resp_word == '0));
endmodule

// File: rtl/spi_banked_regs.sv
module spi_banked_regs
  import spi_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sdout
);
  logic [2:0]            pins_s;
  logic                  frame_ok, frame_bad;
  logic [FRAME_BITS-1:0] frame_word, resp_word;
  logic [NBANK-1:0]      bank_sel;

  // order: {sclk, cs_n, sdi}; cs_n idles high
  spi_pin_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk, cs_n, sdi}),
    .q     (pins_s)
  );

  spi_frame_engine #(.FBITS(FRAME_BITS)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (pins_s[2]),
    .cs_n_s     (pins_s[1]),
    .sdi_s      (pins_s[0]),
    .resp_word  (resp_word),
    .frame_ok   (frame_ok),
    .frame_bad  (frame_bad),
    .frame_word (frame_word),
    .sdout      (sdout)
  );

  spi_bank_store #(.BANKS(NBANK), .AW(ADDR_W), .DW(DATA_W), .FBITS(FRAME_BITS)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_ok   (frame_ok),
    .frame_word (frame_word),
    .resp_word  (resp_word),
    .bank_sel   (bank_sel)
  );

  // R2: a frame of the wrong length touches neither the response nor the bank
  p_bad_len_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> ($stable(resp_word) && $stable(bank_sel)));
endmodule

// File: tb/spi_banked_regs_test.sv
module spi_banked_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdout;

  localparam time HALF = 40;

  always #2 clk = ~clk;

  spi_banked_regs uut (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .sdi   (sdi),
    .sdout (sdout)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic [23:0] rx_box;
  event        rx_ev;

  // reference model built from the requirements
  logic [15:0] mdl [3][256];
  int          mbank = 0;
  logic [23:0] mresp = '0;

  function automatic logic [23:0] rd(input logic [7:0] a);
    return {8'h01, a, 8'h01};
  endfunction

  function automatic logic [23:0] wr(input logic [7:0] a, input logic [15:0] d);
    return {a, d};
  endfunction

  task automatic model_apply(input logic [23:0] tx);
    logic [7:0]  cmd, a;
    logic [15:0] pay;
    cmd = tx[23:16];
    pay = tx[15:0];
    a   = tx[15:8];
    if (cmd == 8'h01 && tx[7:0] == 8'h01)
      mresp = {(a == 8'h02) ? 16'(1 << mbank) : mdl[mbank][a], 8'h00};
    else
      mresp = '0;
    if (cmd > 8'h01) begin
      if (cmd == 8'h02) begin
        if (pay == 16'h0001) mbank = 0;
        else if (pay == 16'h0002) mbank = 1;
        else if (pay == 16'h0004) mbank = 2;
      end else begin
        mdl[mbank][cmd] = pay;
      end
    end
  endtask

  // driver: pushes the expected response, then runs the frame
  task automatic xfer(input logic [23:0] tx, input int nbits, input bit chk, input string tag);
    logic [23:0] rx, sh;
    rx = '0;
    sh = tx;
    if (chk) begin
      exp_q.push_back(mresp);
      tag_q.push_back(tag);
    end
    sdi  = sh[23];
    cs_n = 1'b0;
    #HALF;
    for (int i = 0; i < nbits; i++) begin
      if (i < 24) rx[23-i] = sdout;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
      sh  = sh << 1;
      sdi = sh[23];
      #HALF;
    end
    cs_n = 1'b1;
    sdi  = 1'b0;
    if (chk) begin
      rx_box = rx;
      -> rx_ev;
    end
    if (nbits == 24) model_apply(tx);
    #(4*HALF);
  endtask

  task automatic direct_check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %06h expected %06h", tag, got, exp);
    end
  endtask

  // monitor: pops each expected item as a frame completes
  initial begin
    logic [23:0] e;
    string t;
    forever begin
      @(rx_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rx_box !== e) begin
        errors++;
        $display("FAIL %s: sdout frame got %06h expected %06h", t, rx_box, e);
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    #80;
    rst_n = 1'b1;
    #40;
    direct_check("R1 idle sdout", 24'(sdout), 24'h0);

    // R1: nothing pending, bank 0 after reset
    xfer(24'h000000, 24, 1'b1, "R1 first frame");
    xfer(rd(8'h02),  24, 1'b1, "R6 first read");
    xfer(24'h000000, 24, 1'b1, "R1 reset bank");

    // R3/R4: fill the same address in each bank
    xfer(wr(8'h10, 16'hA5A5), 24, 1'b1, "R3 write b0");
    xfer(wr(8'h11, 16'h1234), 24, 1'b1, "R3 write b0");
    xfer(wr(8'h02, 16'h0002), 24, 1'b1, "R4 sel b1");
    xfer(wr(8'h10, 16'h5A5A), 24, 1'b1, "R3 write b1");
    xfer(wr(8'h02, 16'h0004), 24, 1'b1, "R4 sel b2");
    xfer(wr(8'h10, 16'h0F0F), 24, 1'b1, "R3 write b2");
    xfer(wr(8'h02, 16'h0001), 24, 1'b1, "R4 sel b0 from b2");

    // R7: streamed reads then flush
    xfer(rd(8'h10),  24, 1'b1, "R7 read stream 1");
    xfer(rd(8'h11),  24, 1'b1, "R7 read stream 2");
    xfer(rd(8'h02),  24, 1'b1, "R7 read stream 3");
    xfer(24'h000000, 24, 1'b1, "R8 flush returns pending");
    xfer(24'h000000, 24, 1'b1, "R8 after flush zero");

    // R10: bank steering of reads
    xfer(wr(8'h02, 16'h0004), 24, 1'b1, "R4 sel b2");
    xfer(rd(8'h10),  24, 1'b1, "R10 read b2");
    xfer(wr(8'h02, 16'h0002), 24, 1'b1, "R10 sel b1 after read");
    xfer(rd(8'h10),  24, 1'b1, "R10 b2 data kept");
    xfer(24'h000000, 24, 1'b1, "R10 read b1");

    // R5: rejected selections
    xfer(wr(8'h02, 16'h0003), 24, 1'b1, "R5 two bits");
    xfer(wr(8'h02, 16'h0000), 24, 1'b1, "R5 zero");
    xfer(wr(8'h02, 16'h0008), 24, 1'b1, "R5 out of range");
    xfer(rd(8'h02),  24, 1'b1, "R5 read sel");
    xfer(24'h000000, 24, 1'b1, "R5 still b1");

    // R2: wrong lengths change nothing
    xfer(rd(8'h10),  24, 1'b1, "R2 load pending");
    xfer(wr(8'h10, 16'hFFFF), 23, 1'b0, "R2 short");
    xfer(wr(8'h02, 16'h0001), 25, 1'b0, "R2 long");
    xfer(24'h000000, 24, 1'b1, "R2 pending kept");
    xfer(rd(8'h10),  24, 1'b1, "R2 read after bad frames");
    xfer(rd(8'h02),  24, 1'b1, "R2 data unchanged");
    xfer(24'h000000, 24, 1'b1, "R2 bank unchanged");

    // R8: malformed read and write both clear pending
    xfer(rd(8'h10),  24, 1'b1, "R8 setup");
    xfer({8'h01, 8'h10, 8'h00}, 24, 1'b1, "R8 bad marker returns pending");
    xfer(rd(8'h10),  24, 1'b1, "R8 bad marker clears");
    xfer(wr(8'h20, 16'hBEEF), 24, 1'b1, "R7 write after read");
    xfer(24'h000000, 24, 1'b1, "R8 write clears");
    xfer(24'h00ABCD, 24, 1'b1, "R8 idle with payload");

    // R9: bit order with distinct end bits
    xfer(wr(8'h30, 16'h8001), 24, 1'b1, "R9 write");
    xfer(rd(8'h30),  24, 1'b1, "R9 read");
    xfer(rd(8'h20),  24, 1'b1, "R9 order");
    xfer(24'h000000, 24, 1'b1, "R9 flush");

    #(4*HALF);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule